// File: doc/BRIEF.md
# Serial Transceiver Data and Status Register Pair

This block sits between a processor bus and the two shift engines of a serial transceiver. One bus address serves data in both directions. A write there loads a transmit holding register that the output shifter drains. A read there returns a receive holding register that the input shifter fills. A second address returns a small status word.

Characters are 8 or 9 bits long, and parity is optional, even or odd. On transmit, the parity bit takes the place of the top character bit. On receive, the top bit is kept and reads back as the received parity bit. A failed parity check sets an error flag, and that flag can raise an interrupt request. Software clears the flag in two steps: it reads the status word, and then it reads the data. The shifters are outside this block. Each is modelled as a one-cycle strobe that carries a parallel character. Configuration inputs are sampled when a character is written or loaded.

Top module: `serial_data_port`

## Requirements
- R1: After reset, `tx_empty` is 1 and `rx_not_empty`, `parity_err` and `irq` are 0.
- R2: A write to the data address (`bus_addr`=1) loads bits 8:0 of `bus_wdata` into the transmit holding register and ignores bits 31:9. In 8-bit mode (`cfg_nine_bit`=0), bit 8 of `tx_char` is 0. The write clears `tx_empty`. A `tx_take` strobe sets `tx_empty` again. When a write and a take fall in the same cycle, the write wins.
- R3: With `cfg_parity_en`=1, the written top bit is replaced by the parity bit. The top bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. The parity bit is the XOR of the 7 (or 8) bits below it. That XOR is inverted when `cfg_parity_odd`=1.
- R4: A data read returns bit 8:0 = received character and bits 31:9 = 0. In 8-bit mode, bit 8 of the character is 0. With parity enabled, the top bit is the received parity bit as captured.
- R5: An `rx_load` strobe stores `rx_frame` and sets `rx_not_empty` on the next cycle. A data read clears `rx_not_empty`. When a load and a data read fall in the same cycle, the flag stays set.
- R6: With parity enabled, an `rx_load` whose top bit differs from the parity computed per R3 sets `parity_err`, in the same cycle as `rx_not_empty`. With parity disabled, `parity_err` is never set.
- R7: A read of the status address (`bus_addr`=0) returns `parity_err` in bit 0, `rx_not_empty` in bit 1, `tx_empty` in bit 2, and 0 in all other bits. Writes to the status address have no effect. When `bus_rd` is 0, `bus_rdata` is 0.
- R8: A status read arms the clear. The next data read then clears `parity_err`. A data read that is not armed leaves the flag set. A data write between the status read and the data read disarms the clear.
- R9: A new parity error disarms the clear. If it falls in the same cycle as the completing data read, `parity_err` stays set, and a new status read followed by a data read is needed to clear it.
- R10: `irq` is 1 exactly while `parity_err` is 1 and `cfg_pe_irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 1 | 0 = status word, 1 = data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| cfg_nine_bit | input | 1 | 1 = 9-bit characters |
| cfg_parity_en | input | 1 | Parity enable |
| cfg_parity_odd | input | 1 | 1 = odd parity |
| cfg_pe_irq_en | input | 1 | Parity error interrupt enable |
| tx_take | input | 1 | Output shifter takes the held character |
| tx_char | output | 9 | Held transmit character |
| tx_empty | output | 1 | Transmit holding register free |
| rx_load | input | 1 | Input shifter delivers a frame |
| rx_frame | input | 9 | Delivered frame, parity bit included |
| rx_not_empty | output | 1 | Receive holding register full |
| parity_err | output | 1 | Parity error flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock. The first pair is a data read that completes the clear sequence and an `rx_load` carrying a bad frame; the new error must survive, and `rx_not_empty` must stay set. The second pair is a data write and a `tx_take`. The bench places each pair in the same cycle on purpose, both in directed steps and in a long stretch of mixed stimulus. A behavioural model in the bench defines the outcome: the newer event wins. Every output is compared against the model after every edge.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    localparam int CHAR_W   = 9;
    localparam int ST_PE    = 0;
    localparam int ST_RXNE  = 1;
    localparam int ST_TXE   = 2;

    function automatic logic calc_parity(input logic [CHAR_W-1:0] v,
                                         input logic nine,
                                         input logic odd);
        logic p;
        p = ^v[CHAR_W-3:0];
        if (nine) p = p ^ v[CHAR_W-2];
        return p ^ odd;
    endfunction
endpackage

// File: rtl/sdr_tx_hold.sv
module sdr_tx_hold
    import sdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              nine,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              take,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_empty
);
    typedef struct packed {
        logic [CHAR_W-1:0] thr;
        logic              txe;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        logic [CHAR_W-1:0] shaped;
        logic              p;
        st_d   = st_q;
        shaped = wdata;
        p      = calc_parity(wdata, nine, par_odd);
        if (!nine) shaped[CHAR_W-1] = 1'b0;
        if (par_en) begin
            if (nine) shaped[CHAR_W-1] = p;
            else      shaped[CHAR_W-2] = p;
        end
        if (take) st_d.txe = 1'b1;
        if (wr) begin
            st_d.txe = 1'b0;
            st_d.thr = shaped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr <= '0;
            st_q.txe <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_char  = st_q.thr;
    assign tx_empty = st_q.txe;

    p_txe_fall_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr));
    p_write_beats_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !tx_empty);
endmodule

// File: rtl/sdr_rx_hold.sv
module sdr_rx_hold
    import sdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] frame,
    input  logic              nine,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    output logic [CHAR_W-1:0] rdr,
    output logic              rxne,
    output logic              pe
);
    typedef struct packed {
        logic [CHAR_W-1:0] rdr;
        logic              rxne;
        logic              pe;
        logic              arm;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        logic [CHAR_W-1:0] kept;
        logic              top;
        logic              bad;
        st_d = st_q;
        kept = frame;
        if (!nine) kept[CHAR_W-1] = 1'b0;
        top  = nine ? frame[CHAR_W-1] : frame[CHAR_W-2];
        bad  = par_en && (top != calc_parity(frame, nine, par_odd));
        if (data_rd) begin
            st_d.rxne = 1'b0;
            if (st_q.arm) st_d.pe = 1'b0;
            st_d.arm = 1'b0;
        end
        if (data_wr) st_d.arm = 1'b0;
        if (stat_rd) st_d.arm = 1'b1;
        if (load) begin
            st_d.rdr  = kept;
            st_d.rxne = 1'b1;
            if (bad) begin
                st_d.pe  = 1'b1;
                st_d.arm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdr  = st_q.rdr;
    assign rxne = st_q.rxne;
    assign pe   = st_q.pe;

    p_pe_rise_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe) |-> ($past(load) && $past(par_en)));
    p_pe_fall_on_data_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pe) |-> $past(data_rd));
    p_rxne_fall_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxne) |-> $past(data_rd));
    p_load_sets_rxne_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rxne);
    p_pe_sets_with_rxne_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe) |-> rxne);
endmodule

// File: rtl/serial_data_port.sv
module serial_data_port
    import sdr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cfg_nine_bit,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_pe_irq_en,
    input  logic              tx_take,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_empty,
    input  logic              rx_load,
    input  logic [CHAR_W-1:0] rx_frame,
    output logic              rx_not_empty,
    output logic              parity_err,
    output logic              irq
);
    logic              stat_rd, data_rd, data_wr;
    logic [CHAR_W-1:0] rdr;
    logic              unused_wdata_hi;

    assign stat_rd = bus_rd && !bus_addr;
    assign data_rd = bus_rd &&  bus_addr;
    assign data_wr = bus_wr &&  bus_addr;
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CHAR_W];

    sdr_tx_hold u_tx (
        .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(bus_wdata[CHAR_W-1:0]),
        .nine(cfg_nine_bit), .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
        .take(tx_take), .tx_char(tx_char), .tx_empty(tx_empty)
    );

    sdr_rx_hold u_rx (
        .clk(clk), .rst_n(rst_n), .load(rx_load), .frame(rx_frame),
        .nine(cfg_nine_bit), .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
        .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .rdr(rdr), .rxne(rx_not_empty), .pe(parity_err)
    );

    always_comb begin
        bus_rdata = '0;
        if (data_rd) begin
            bus_rdata[CHAR_W-1:0] = rdr;
        end else if (stat_rd) begin
            bus_rdata[ST_PE]   = parity_err;
            bus_rdata[ST_RXNE] = rx_not_empty;
            bus_rdata[ST_TXE]  = tx_empty;
        end
    end

    assign irq = parity_err && cfg_pe_irq_en;

    p_irq_follows_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (parity_err && cfg_pe_irq_en));
    p_data_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> (bus_rdata[BUS_W-1:CHAR_W] == '0));
endmodule

// File: tb/serial_data_port_bench.sv
module serial_data_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 0, bus_wr = 0, bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        cfg_nine_bit = 0, cfg_parity_en = 0, cfg_parity_odd = 0, cfg_pe_irq_en = 0;
    logic        tx_take = 0, rx_load = 0;
    logic [8:0]  rx_frame = 0;
    logic [8:0]  tx_char;
    logic        tx_empty, rx_not_empty, parity_err, irq;

    int vectors = 0;
    int fails = 0;
    int m_thr, m_rdr;
    bit m_txe, m_rxne, m_pe, m_arm;

    always #4 clk = ~clk;

    serial_data_port u_serial_data_port (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_nine_bit(cfg_nine_bit),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_pe_irq_en(cfg_pe_irq_en), .tx_take(tx_take), .tx_char(tx_char),
        .tx_empty(tx_empty), .rx_load(rx_load), .rx_frame(rx_frame),
        .rx_not_empty(rx_not_empty), .parity_err(parity_err), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ones(input int v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if ((v >> i) & 1) c++;
        return c;
    endfunction

    function automatic int exp_par(input int v, input bit nine, input bit odd);
        return (ones(v, nine ? 8 : 7) % 2) ^ int'(odd);
    endfunction

    task automatic check_state();
        check("R2 tx_empty", int'(tx_empty), int'(m_txe));
        check("R2/R3 tx_char", int'(tx_char), m_thr);
        check("R5 rx_not_empty", int'(rx_not_empty), int'(m_rxne));
        check("R6/R8/R9 parity_err", int'(parity_err), int'(m_pe));
        check("R10 irq", int'(irq), int'(m_pe && cfg_pe_irq_en));
    endtask

    task automatic step(input bit rd, input bit wr, input bit addr, input int wd,
                        input bit ld, input int fr, input bit tk);
        int pos, v;
        bit nrxne, npe, narm, ntxe;
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        rx_load = ld; rx_frame = fr[8:0]; tx_take = tk;
        #2;
        if (rd && addr)  check("R4 data read", int'(bus_rdata), m_rdr);
        else if (rd)     check("R7 status read", int'(bus_rdata),
                               int'(m_pe) | (int'(m_rxne) << 1) | (int'(m_txe) << 2));
        else             check("R7 idle rdata", int'(bus_rdata), 0);
        pos = cfg_nine_bit ? 8 : 7;
        ntxe = m_txe; nrxne = m_rxne; npe = m_pe; narm = m_arm;
        if (tk) ntxe = 1;
        if (wr && addr) begin
            v = wd & 32'h1FF;
            if (!cfg_nine_bit) v = v & 32'hFF;
            if (cfg_parity_en)
                v = (v & ~(1 << pos)) | (exp_par(wd, cfg_nine_bit, cfg_parity_odd) << pos);
            m_thr = v; ntxe = 0;
        end
        if (rd && addr) begin
            nrxne = 0;
            if (m_arm) npe = 0;
            narm = 0;
        end
        if (wr && addr) narm = 0;
        if (rd && !addr) narm = 1;
        if (ld) begin
            v = fr & (cfg_nine_bit ? 32'h1FF : 32'hFF);
            m_rdr = v; nrxne = 1;
            if (cfg_parity_en && (((fr >> pos) & 1) != exp_par(fr, cfg_nine_bit, cfg_parity_odd))) begin
                npe = 1; narm = 0;
            end
        end
        @(posedge clk);
        m_txe = ntxe; m_rxne = nrxne; m_pe = npe; m_arm = narm;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; rx_load = 0; tx_take = 0;
        check_state();
    endtask

    task automatic cfg(input bit nine, input bit pen, input bit odd, input bit ie);
        cfg_nine_bit = nine; cfg_parity_en = pen; cfg_parity_odd = odd; cfg_pe_irq_en = ie;
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        m_thr = 0; m_rdr = 0; m_txe = 1; m_rxne = 0; m_pe = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 rx_not_empty", int'(rx_not_empty), 0);
        check("R1 parity_err", int'(parity_err), 0);
        check("R1 irq", int'(irq), 0);
        // R2 8-bit, upper bits ignored; take, then write+take together
        cfg(0, 0, 0, 1);
        step(0, 1, 1, 32'hFFFF_F1A5, 0, 0, 0);
        check("R2 tx_char 8-bit", int'(tx_char), 32'hA5);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 1, 1, 32'h0000_0133, 0, 0, 1);
        check("R2 write beats take", int'(tx_empty), 0);
        step(0, 1, 0, 32'h0000_0007, 0, 0, 0);   // R7 status write ignored
        step(1, 0, 0, 0, 0, 0, 0);
        // R3 parity replacement, both lengths and senses
        cfg(1, 0, 0, 0); step(0, 1, 1, 32'h1A5, 0, 0, 0);
        cfg(0, 1, 0, 0); step(0, 1, 1, 32'h087, 0, 0, 0);
        check("R3 even 8-bit", int'(tx_char), 32'h087);
        cfg(0, 1, 1, 0); step(0, 1, 1, 32'h087, 0, 0, 0);
        check("R3 odd 8-bit", int'(tx_char), 32'h007);
        cfg(1, 1, 0, 0); step(0, 1, 1, 32'h003, 0, 0, 0);
        check("R3 even 9-bit", int'(tx_char), 32'h003);
        cfg(1, 1, 1, 0); step(0, 1, 1, 32'h003, 0, 0, 0);
        check("R3 odd 9-bit", int'(tx_char), 32'h103);
        // R4/R5/R6 receive
        cfg(0, 0, 0, 1); step(0, 0, 0, 0, 1, 32'h1C3, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R6 no error with parity off", int'(parity_err), 0);
        cfg(0, 1, 0, 1); step(0, 0, 0, 0, 1, 32'h081, 0);   // good even frame
        check("R6 good frame", int'(parity_err), 0);
        step(0, 0, 0, 0, 1, 32'h001, 0);                     // bad frame
        check("R6 bad frame", int'(parity_err), 1);
        check("R10 irq raised", int'(irq), 1);
        // R8 unarmed read leaves flag; write disarms; proper sequence clears
        step(1, 0, 1, 0, 0, 0, 0);
        check("R8 unarmed read", int'(parity_err), 1);
        step(1, 0, 0, 0, 0, 0, 0); step(0, 1, 1, 32'h55, 0, 0, 0); step(1, 0, 1, 0, 0, 0, 0);
        check("R8 write disarms", int'(parity_err), 1);
        step(1, 0, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 0, 0, 0);
        check("R8 sequence clears", int'(parity_err), 0);
        // R9 new error with completing read
        cfg(1, 1, 1, 1); step(0, 0, 0, 0, 1, 32'h000, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 1, 32'h000, 0);
        check("R9 new error survives", int'(parity_err), 1);
        check("R5 load beats read", int'(rx_not_empty), 1);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R9 still set without status read", int'(parity_err), 1);
        step(1, 0, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 0, 0, 0);
        check("R9 cleared after fresh sequence", int'(parity_err), 0);
        // mixed stimulus
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom % 4;
            if (i % 97 == 0) cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
            step(k == 1, k == 2, $urandom % 4 != 0, $urandom, ($urandom % 3) == 0,
                 $urandom, ($urandom % 3) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule